// File: doc/BRIEF.md
# Oversampled Serial Receiver with Read-Sequenced Status

This block takes an asynchronous serial line, oversamples it with a tick supplied from outside (sixteen ticks per bit by default), and assembles frames of one start bit, eight or nine data bits sent least significant first, and one stop bit. When the stop position is sampled, the assembled data moves into a holding register. The full flag, the framing-error flag and the parity-error flag are updated in the same cycle.

A host sees two read strobes. The status strobe returns four flags. The data strobe returns the held word and carries a two-bit byte-lane qualifier. A flag is cleared only when the host has read status while that flag was set and then reads data through the low byte lane. There is one interrupt, and it follows the full flag. The host checks the error flags while it services that interrupt.

Top module: `serial_rx_status`

## Requirements
- R1: In 8-bit mode (`nineBit`=0) a frame's data bits arrive least significant first and appear in `rxData[7:0]`. The full flag (`statusWord[0]`) sets when the stop position is sampled.
- R2: The framing-error flag (`statusWord[1]`) sets if the stop position samples 0, and a break (every position 0) also sets it. It sets in the same cycle as the full flag.
- R3: In 9-bit mode the ninth received bit appears in `rxData[8]`. In 8-bit mode `rxData[8]` reads 0. `rxData[15:9]` always reads 0.
- R4: A status read while a flag is set, followed by a data read with `dataLanes[0]`=1, clears that flag.
- R5: A data read clears no flag unless a status read saw that flag set since the last data read.
- R6: A data read with `dataLanes[0]`=0 (upper byte only) does not count as the data read of the clear sequence.
- R7: With `parityEn`=1 the last data bit is parity. `statusWord[2]` sets when the XOR of all data bits, parity included, differs from `parityOdd`. With `parityEn`=0 it never sets.
- R8: `irq` is high exactly while the full flag is set. There is no separate error interrupt.
- R9: A frame that completes while the full flag is set leaves `rxData` and the error flags unchanged and sets the overrun flag (`statusWord[3]`). The same read sequence clears the overrun flag.
- R10: The start bit is taken as the majority of three samples near mid-bit. A low pulse that is high again by then is rejected, and no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxLine | input | 1 | Serial input, idle high |
| sampleTick | input | 1 | Oversampling enable, OVS pulses per bit |
| nineBit | input | 1 | 1 selects nine data bits, 0 selects eight |
| parityEn | input | 1 | Treat the last data bit as parity |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| statusRd | input | 1 | Status read strobe, arms the clear sequence |
| dataRd | input | 1 | Data read strobe |
| dataLanes | input | 2 | Byte lanes of the data read, bit 0 is the low byte |
| statusWord | output | 4 | {overrun, parity error, framing error, full} |
| rxData | output | 16 | Held data, zero above bit 8 |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest states to reach are an overrun and a break. Overrun needs a second whole frame to finish before the host has run its clear sequence. The bench reaches it by sending two frames back to back and checking that the first word is still held. A break drives the line low through the stop position, so the receiver can re-arm on the tail of the break. The bench returns the line high before the next mid-bit vote, lets the line settle, and then confirms that one full clear sequence leaves every flag at zero.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef struct packed {
    logic restartCnt;
    logic shiftEn;
    logic loadHold;
  } srxStrobe_t;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  localparam int NUM_FLAGS   = 4;
  localparam int FLAG_FULL   = 0;
  localparam int FLAG_FRAME  = 1;
  localparam int FLAG_PARITY = 2;
  localparam int FLAG_OVER   = 3;
endpackage

// File: rtl/srx_dp.sv
module srx_dp
  import srx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              nineBit,
  input  logic              parityOdd,
  input  srxStrobe_t        strobe,
  output logic              lineLow,
  output logic              voteBit,
  output logic              bitMid,
  output logic              bitEnd,
  output logic              parityBad,
  output logic [BASE_W:0]   holdData
);
  localparam int CNT_W  = $clog2(OVS);
  localparam int FULL_W = BASE_W + 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] SMP0_CNT = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SMP1_CNT = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] END_CNT  = CNT_W'(OVS - 1);

  logic [1:0]        syncQ;
  logic [CNT_W-1:0]  tickCnt;
  logic              smp0, smp1;
  logic [FULL_W-1:0] shiftQ;
  logic [FULL_W-1:0] candWord;
  logic              lineNow;

  assign lineNow = syncQ[1];
  assign lineLow = !lineNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
      smp0    <= 1'b1;
      smp1    <= 1'b1;
    end else if (strobe.restartCnt) begin
      tickCnt <= '0;
    end else if (sampleTick) begin
      tickCnt <= tickCnt + 1'b1;
      if (tickCnt == SMP0_CNT) smp0 <= lineNow;
      if (tickCnt == SMP1_CNT) smp1 <= lineNow;
    end
  end

  assign bitMid  = sampleTick && (tickCnt == MID_CNT);
  assign bitEnd  = sampleTick && (tickCnt == END_CNT);
  assign voteBit = (smp0 & smp1) | (smp0 & lineNow) | (smp1 & lineNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftQ <= '0;
    else if (strobe.shiftEn) shiftQ <= {voteBit, shiftQ[FULL_W-1:1]};
  end

  assign candWord  = nineBit ? shiftQ : {1'b0, shiftQ[FULL_W-1:1]};
  assign parityBad = (^candWord) ^ parityOdd;

  always_ff @(posedge clk) begin
    if (strobe.loadHold) holdData <= candWord;
  end
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl
  import srx_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 nineBit,
  input  logic                 parityEn,
  input  logic                 statusRd,
  input  logic                 dataRd,
  input  logic                 dataLow,
  input  logic                 lineLow,
  input  logic                 voteBit,
  input  logic                 bitMid,
  input  logic                 bitEnd,
  input  logic                 parityBad,
  output srxStrobe_t           strobe,
  output logic [NUM_FLAGS-1:0] flags
);
  localparam int IDX_W = $clog2(BASE_W + 1);

  rxState_t             state;
  logic [IDX_W-1:0]     bitIdx;
  logic [IDX_W-1:0]     lastIdx;
  logic [NUM_FLAGS-1:0] armQ;
  logic [NUM_FLAGS-1:0] keptFlags;
  logic [NUM_FLAGS-1:0] nextFlags;
  logic                 frameDone;
  logic                 dataAccess;

  assign lastIdx    = nineBit ? IDX_W'(BASE_W) : IDX_W'(BASE_W - 1);
  assign frameDone  = (state == RX_STOP) && bitMid;
  assign dataAccess = dataRd && dataLow;
  assign keptFlags  = flags & ~(dataAccess ? armQ : '0);

  always_comb begin
    strobe.restartCnt = (state == RX_IDLE) && lineLow;
    strobe.shiftEn    = (state == RX_DATA) && bitMid;
    strobe.loadHold   = frameDone && !keptFlags[FLAG_FULL];
  end

  always_comb begin
    nextFlags = keptFlags;
    if (frameDone) begin
      if (keptFlags[FLAG_FULL]) begin
        nextFlags[FLAG_OVER] = 1'b1;
      end else begin
        nextFlags[FLAG_FULL]   = 1'b1;
        nextFlags[FLAG_FRAME]  = !voteBit;
        nextFlags[FLAG_PARITY] = parityEn && parityBad;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags <= '0;
      armQ  <= '0;
    end else begin
      flags <= nextFlags;
      if (statusRd)        armQ <= flags;
      else if (dataAccess) armQ <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= RX_IDLE;
      bitIdx <= '0;
    end else begin
      unique case (state)
        RX_IDLE:  if (lineLow) state <= RX_START;
        RX_START: begin
          if (bitMid && voteBit) state <= RX_IDLE;
          else if (bitEnd) begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end
        end
        RX_DATA:  if (bitEnd) begin
          if (bitIdx == lastIdx) state <= RX_STOP;
          else                   bitIdx <= bitIdx + 1'b1;
        end
        RX_STOP:  if (bitMid) state <= RX_IDLE;
        default:  state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import srx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int BASE_W = 8,
  parameter int BUS_W  = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 sampleTick,
  input  logic                 nineBit,
  input  logic                 parityEn,
  input  logic                 parityOdd,
  input  logic                 statusRd,
  input  logic                 dataRd,
  input  logic [1:0]           dataLanes,
  output logic [NUM_FLAGS-1:0] statusWord,
  output logic [BUS_W-1:0]     rxData,
  output logic                 irq
);
  localparam int PAD_W = BUS_W - BASE_W - 1;

  srxStrobe_t     strobe;
  logic           lineLow, voteBit, bitMid, bitEnd, parityBad;
  logic [BASE_W:0] holdData;

  srx_dp #(.OVS(OVS), .BASE_W(BASE_W)) dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .nineBit(nineBit), .parityOdd(parityOdd), .strobe(strobe),
    .lineLow(lineLow), .voteBit(voteBit), .bitMid(bitMid), .bitEnd(bitEnd),
    .parityBad(parityBad), .holdData(holdData)
  );

  srx_ctrl #(.BASE_W(BASE_W)) ctrl (
    .clk(clk), .rstN(rstN), .nineBit(nineBit), .parityEn(parityEn),
    .statusRd(statusRd), .dataRd(dataRd), .dataLow(dataLanes[0]),
    .lineLow(lineLow), .voteBit(voteBit), .bitMid(bitMid), .bitEnd(bitEnd),
    .parityBad(parityBad), .strobe(strobe), .flags(statusWord)
  );

  assign rxData = {{PAD_W{1'b0}}, holdData};
  assign irq    = statusWord[FLAG_FULL];
endmodule

// File: rtl/srx_chk.sv
module srx_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  statusWord,
  input logic [15:0] rxData,
  input logic        irq,
  input logic        parityEn,
  input logic        dataRd,
  input logic [1:0]  dataLanes
);
  AST_FRAME_WITH_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[1]) |-> statusWord[0]); // R2
  AST_PARITY_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[2]) |-> ($past(parityEn) && statusWord[0])); // R7
  AST_FULL_CLEARS_ON_LOW_LANE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[0]) |-> $past(dataRd && dataLanes[0])); // R4
  AST_ERR_KEPT_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusWord[1]) |-> $past(dataRd && dataLanes[0])); // R5
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusWord[3]) |-> $stable(rxData)); // R9
  AST_IRQ_ONLY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $rose(statusWord[0])); // R8
endmodule

bind serial_rx_status srx_chk chk (
  .clk(clk), .rstN(rstN), .statusWord(statusWord), .rxData(rxData), .irq(irq),
  .parityEn(parityEn), .dataRd(dataRd), .dataLanes(dataLanes)
);

// File: tb/serial_rx_status_test.sv
module serial_rx_status_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxLine = 1'b1;
  logic        sampleTick = 1'b0;
  logic        nineBit = 1'b0, parityEn = 1'b0, parityOdd = 1'b0;
  logic        statusRd = 1'b0, dataRd = 1'b0;
  logic [1:0]  dataLanes = 2'b00;
  logic [3:0]  statusWord;
  logic [15:0] rxData;
  logic        irq;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  localparam int BIT_CLKS = 32;

  serial_rx_status uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .nineBit(nineBit), .parityEn(parityEn), .parityOdd(parityOdd),
    .statusRd(statusRd), .dataRd(dataRd), .dataLanes(dataLanes),
    .statusWord(statusWord), .rxData(rxData), .irq(irq)
  );

  always #4 clk = ~clk;

  always @(negedge clk) sampleTick <= ~sampleTick;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    waitClk(BIT_CLKS);
  endtask

  task automatic sendFrame(input logic [8:0] d, input int nbits, input logic stopV);
    sendBit(1'b0);
    for (int i = 0; i < nbits; i++) sendBit(d[i]);
    sendBit(stopV);
    rxLine = 1'b1;
    waitClk(8);
  endtask

  task automatic readStatus();
    statusRd = 1'b1;
    waitClk(1);
    statusRd = 1'b0;
    waitClk(1);
  endtask

  task automatic readData(input logic [1:0] lanes);
    dataRd = 1'b1;
    dataLanes = lanes;
    waitClk(1);
    dataRd = 1'b0;
    dataLanes = 2'b00;
    waitClk(1);
  endtask

  task automatic clearAll();
    readStatus();
    readData(2'b01);
  endtask

  task automatic testReset();
    check("R8 reset status", {12'h0, statusWord}, 16'h0);
    check("R8 reset irq", {15'h0, irq}, 16'h0);
  endtask

  task automatic testBasic();
    nineBit = 0; parityEn = 0;
    sendFrame(9'h0A5, 8, 1'b1);
    check("R1 data", rxData, 16'h00A5);
    check("R1 status full only", {12'h0, statusWord}, 16'h0001);
    check("R8 irq follows full", {15'h0, irq}, 16'h1);
    readStatus();
    readData(2'b01);
    check("R4 cleared", {12'h0, statusWord}, 16'h0);
    check("R8 irq low after clear", {15'h0, irq}, 16'h0);
  endtask

  task automatic testNoStatusRead();
    sendFrame(9'h05A, 8, 1'b1);
    readData(2'b01);
    check("R5 data read alone keeps full", {12'h0, statusWord}, 16'h0001);
    readStatus();
    readData(2'b10);
    check("R6 upper lane ignored", {12'h0, statusWord}, 16'h0001);
    readData(2'b11);
    check("R6 word access clears", {12'h0, statusWord}, 16'h0);
  endtask

  task automatic testFraming();
    sendFrame(9'h03C, 8, 1'b0);
    check("R2 framing flag with full", {12'h0, statusWord}, 16'h0003);
    check("R2 framing data", rxData, 16'h003C);
    waitClk(400);
    clearAll();
    check("R4 framing cleared", {12'h0, statusWord}, 16'h0);
  endtask

  task automatic testBreak();
    sendFrame(9'h000, 8, 1'b0);
    check("R2 break flags", {12'h0, statusWord}, 16'h0003);
    check("R2 break data", rxData, 16'h0000);
    waitClk(400);
    clearAll();
    check("R2 break cleared", {12'h0, statusWord}, 16'h0);
  endtask

  task automatic testNineBit();
    nineBit = 1;
    sendFrame(9'h1C3, 9, 1'b1);
    check("R3 ninth bit held", rxData, 16'h01C3);
    clearAll();
    nineBit = 0;
    sendFrame(9'h0FF, 8, 1'b1);
    check("R3 eight bit mode bit8 zero", rxData, 16'h00FF);
    clearAll();
  endtask

  task automatic testParity();
    parityEn = 1; parityOdd = 0;
    sendFrame(9'h003, 8, 1'b1);
    check("R7 even good", {12'h0, statusWord}, 16'h0001);
    clearAll();
    sendFrame(9'h007, 8, 1'b1);
    check("R7 even bad", {12'h0, statusWord}, 16'h0005);
    readData(2'b01);
    check("R5 parity kept without status read", {12'h0, statusWord}, 16'h0005);
    clearAll();
    check("R4 parity cleared", {12'h0, statusWord}, 16'h0);
    parityOdd = 1;
    sendFrame(9'h007, 8, 1'b1);
    check("R7 odd good", {12'h0, statusWord}, 16'h0001);
    clearAll();
    nineBit = 1;
    sendFrame(9'h101, 9, 1'b1);
    check("R7 odd nine bit bad", {12'h0, statusWord}, 16'h0005);
    clearAll();
    nineBit = 0; parityEn = 0; parityOdd = 0;
    sendFrame(9'h007, 8, 1'b1);
    check("R7 disabled", {12'h0, statusWord}, 16'h0001);
    clearAll();
  endtask

  task automatic testOverrun();
    sendFrame(9'h011, 8, 1'b1);
    sendFrame(9'h022, 8, 1'b0);
    check("R9 old data kept", rxData, 16'h0011);
    check("R9 overrun flag, no framing", {12'h0, statusWord}, 16'h0009);
    waitClk(400);
    clearAll();
    check("R9 overrun cleared", {12'h0, statusWord}, 16'h0);
  endtask

  task automatic testNoise();
    rxLine = 1'b0;
    waitClk(6);
    rxLine = 1'b1;
    waitClk(400);
    check("R10 glitch rejected", {12'h0, statusWord}, 16'h0);
    sendFrame(9'h081, 8, 1'b1);
    check("R10 frame after glitch", rxData, 16'h0081);
    clearAll();
  endtask

  initial begin
    waitClk(5);
    rstN = 1'b1;
    waitClk(40);
    testReset();
    testBasic();
    testNoStatusRead();
    testFraming();
    testBreak();
    testNineBit();
    testParity();
    testOverrun();
    testNoise();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule